// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This unit provides hazard control for a five-stage in-order pipeline (fetch, decode, compute, memory, writeback). Each cycle it looks at the instruction in decode: its two source register ids and their use flags, its destination id, whether it writes a register, and whether it is a load. It keeps a small shadow of the destination fields of the three older in-flight instructions. These sit in the decode/compute, compute/memory and memory/writeback buffers. The register file, ALU and memories stay outside. The surrounding pipeline uses the outputs to steer its own multiplexers and to freeze its own registers.

A load result only exists after the memory stage. An instruction that consumes it immediately is held in decode for one cycle, and the decode/compute slot receives a bubble. After that the load result is forwarded from the memory/writeback buffer. Results of ALU instructions are forwarded to the instruction in compute from whichever of the two later buffers holds the youngest matching writer. For a writer that is leaving writeback while the reader sits in decode, a bypass flag tells decode to capture the writeback data instead of the register file value. A mode input turns forwarding off. The unit then stalls decode until every older matching writer has passed writeback.

Top module: `hz_unit`

## Requirements
- R1: After reset, and while decode holds no valid instruction, `stall_o` is 0, both select outputs are 00 and both bypass flags are 0.
- R2: With forwarding on, a decode source that matches the destination of a load in the decode/compute slot raises `stall_o` for exactly one cycle.
- R3: With forwarding on, each operand select for the instruction in compute is 01 when its source matches the compute/memory writer. The select encoding is 00 = register file, 01 = compute/memory buffer, 10 = memory/writeback buffer, and 11 is never produced.
- R4: With forwarding on, an operand select is 10 when its source matches only the memory/writeback writer.
- R5: When both later buffers match one source, the select is 01 (the younger result wins).
- R6: Register 0, an instruction that does not write a register, and a source whose use flag is 0 never produce a match, a stall, a non-zero select or a bypass.
- R7: With forwarding off, decode stalls while any of the three older slots holds a matching writer. A reader directly after its producer stalls 3 cycles, and a reader two behind it stalls 2. Both selects stay 00.
- R8: A stall writes a bubble into the decode/compute slot, not a copy of the held instruction. After a load-use stall, the dependent instruction in compute sees select 10, not 01.
- R9: With forwarding on, a non-stalled decode source that matches the memory/writeback writer raises that operand's bypass flag (`wb_byp_a_o` for source 1, `wb_byp_b_o` for source 2).
- R10: With forwarding on, a dependence on an ALU (non-load) result never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_en_i | input | 1 | 1 = forwarding mode, 0 = stall-until-writeback mode |
| dec_valid_i | input | 1 | Decode holds a valid instruction |
| dec_rs1_i | input | AW | Decode source register 1 id |
| dec_use_rs1_i | input | 1 | Source 1 is read |
| dec_rs2_i | input | AW | Decode source register 2 id |
| dec_use_rs2_i | input | 1 | Source 2 is read |
| dec_rd_i | input | AW | Decode destination register id |
| dec_wr_i | input | 1 | Decode instruction writes a register |
| dec_load_i | input | 1 | Decode instruction is a load |
| stall_o | output | 1 | Freeze PC and fetch/decode buffer; bubble into decode/compute |
| fwd_a_o | output | 2 | Select for ALU operand A (source 1) of the instruction in compute |
| fwd_b_o | output | 2 | Select for ALU operand B (source 2) of the instruction in compute |
| wb_byp_a_o | output | 1 | Decode captures writeback data for source 1 |
| wb_byp_b_o | output | 1 | Decode captures writeback data for source 2 |

## Verification
Directed sequences place a consumer one, two and three instructions behind its producer. This separates the compute/memory select, the memory/writeback select and the decode bypass. A consumer behind two writers of the same register tells whether the younger value wins. A consumer directly behind a load, run in both modes, shows the one-bubble and the three-cycle stall lengths and shows that the bubble does not alias the held instruction. Writers to register 0, non-writing producers and unused sources confirm that false matches are suppressed. A long random stream over a narrow register range, with loads, idle slots and mode flips, is then compared cycle by cycle against a bench pipeline model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_CM = 2'b01,
    SEL_MW = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int unsigned AW = 5
) (
  input  logic          valid_i,
  input  logic          wr_i,
  input  logic          use_i,
  input  logic [AW-1:0] rd_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  // register 0 is hardwired and never tracked
  assign hit_o = valid_i && wr_i && use_i && (rd_i != '0) && (rd_i == src_i);
endmodule

// File: rtl/hz_track.sv
module hz_track #(
  parameter int unsigned AW     = 5,
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned N_SLOT = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stall_i,
  input  logic                        dec_valid_i,
  input  logic                        dec_wr_i,
  input  logic                        dec_load_i,
  input  logic [AW-1:0]               dec_rd_i,
  input  logic [N_SRC-1:0][AW-1:0]    dec_rs_i,
  input  logic [N_SRC-1:0]            dec_use_i,
  output logic [N_SLOT-1:0]           st_valid_o,
  output logic [N_SLOT-1:0]           st_wr_o,
  output logic [N_SLOT-1:0][AW-1:0]   st_rd_o,
  output logic                        dc_load_o,
  output logic [N_SRC-1:0][AW-1:0]    dc_rs_o,
  output logic [N_SRC-1:0]            dc_use_o
);
  logic take;
  assign take = dec_valid_i && !stall_i;

  // slot 0: decode/compute, carries sources for the compute-stage selects
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid_o[0] <= 1'b0;
      st_wr_o[0]    <= 1'b0;
      st_rd_o[0]    <= '0;
      dc_load_o     <= 1'b0;
      dc_rs_o       <= '0;
      dc_use_o      <= '0;
    end else if (take) begin
      st_valid_o[0] <= 1'b1;
      st_wr_o[0]    <= dec_wr_i;
      st_rd_o[0]    <= dec_rd_i;
      dc_load_o     <= dec_load_i;
      dc_rs_o       <= dec_rs_i;
      dc_use_o      <= dec_use_i;
    end else begin
      // bubble
      st_valid_o[0] <= 1'b0;
      st_wr_o[0]    <= 1'b0;
      dc_load_o     <= 1'b0;
      dc_use_o      <= '0;
    end
  end

  for (genvar s = 1; s < N_SLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_valid_o[s] <= 1'b0;
        st_wr_o[s]    <= 1'b0;
        st_rd_o[s]    <= '0;
      end else begin
        st_valid_o[s] <= st_valid_o[s-1];
        st_wr_o[s]    <= st_wr_o[s-1];
        st_rd_o[s]    <= st_rd_o[s-1];
      end
    end
  end
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int unsigned AW     = 5,
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned N_SLOT = 3
) (
  input  logic                        fwd_en_i,
  input  logic                        dec_valid_i,
  input  logic [N_SRC-1:0][AW-1:0]    dec_rs_i,
  input  logic [N_SRC-1:0]            dec_use_i,
  input  logic [N_SLOT-1:0]           st_valid_i,
  input  logic [N_SLOT-1:0]           st_wr_i,
  input  logic [N_SLOT-1:0][AW-1:0]   st_rd_i,
  input  logic                        dc_load_i,
  output logic                        stall_o,
  output logic [N_SRC-1:0]            wb_byp_o
);
  localparam int unsigned LAST = N_SLOT - 1;

  logic [N_SRC-1:0][N_SLOT-1:0] hit;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      hz_match #(.AW(AW)) u_match (
        .valid_i (st_valid_i[s]),
        .wr_i    (st_wr_i[s]),
        .use_i   (dec_use_i[k]),
        .rd_i    (st_rd_i[s]),
        .src_i   (dec_rs_i[k]),
        .hit_o   (hit[k][s])
      );
    end
  end

  logic any_hit, load_hit;
  always_comb begin
    any_hit  = 1'b0;
    load_hit = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      any_hit  = any_hit | (|hit[k]);
      load_hit = load_hit | hit[k][0];
    end
    load_hit = load_hit & dc_load_i;
    stall_o  = dec_valid_i && (fwd_en_i ? load_hit : any_hit);
    for (int k = 0; k < N_SRC; k++)
      wb_byp_o[k] = fwd_en_i && dec_valid_i && !stall_o && hit[k][LAST];
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int unsigned AW = 5
) (
  input  logic              fwd_en_i,
  input  logic              dc_valid_i,
  input  logic [AW-1:0]     src_i,
  input  logic              use_i,
  input  logic              cm_valid_i,
  input  logic              cm_wr_i,
  input  logic [AW-1:0]     cm_rd_i,
  input  logic              mw_valid_i,
  input  logic              mw_wr_i,
  input  logic [AW-1:0]     mw_rd_i,
  output hz_pkg::fwd_sel_e  sel_o
);
  logic cm_hit, mw_hit;

  hz_match #(.AW(AW)) u_cm (
    .valid_i(cm_valid_i), .wr_i(cm_wr_i), .use_i(use_i),
    .rd_i(cm_rd_i), .src_i(src_i), .hit_o(cm_hit)
  );
  hz_match #(.AW(AW)) u_mw (
    .valid_i(mw_valid_i), .wr_i(mw_wr_i), .use_i(use_i),
    .rd_i(mw_rd_i), .src_i(src_i), .hit_o(mw_hit)
  );

  always_comb begin
    sel_o = hz_pkg::SEL_RF;
    if (fwd_en_i && dc_valid_i) begin
      if (cm_hit)      sel_o = hz_pkg::SEL_CM; // younger result first
      else if (mw_hit) sel_o = hz_pkg::SEL_MW;
    end
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwd_en_i,
  input  logic          dec_valid_i,
  input  logic [AW-1:0] dec_rs1_i,
  input  logic          dec_use_rs1_i,
  input  logic [AW-1:0] dec_rs2_i,
  input  logic          dec_use_rs2_i,
  input  logic [AW-1:0] dec_rd_i,
  input  logic          dec_wr_i,
  input  logic          dec_load_i,
  output logic          stall_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          wb_byp_a_o,
  output logic          wb_byp_b_o
);
  localparam int unsigned N_SRC  = 2;
  localparam int unsigned N_SLOT = 3;
  localparam int unsigned S_CM   = 1;
  localparam int unsigned S_MW   = 2;

  logic [N_SRC-1:0][AW-1:0]  dec_rs, dc_rs;
  logic [N_SRC-1:0]          dec_use, dc_use, wb_byp;
  logic [N_SLOT-1:0]         st_valid, st_wr;
  logic [N_SLOT-1:0][AW-1:0] st_rd;
  logic                      dc_load;
  hz_pkg::fwd_sel_e          sel [N_SRC];

  assign dec_rs  = {dec_rs2_i, dec_rs1_i};
  assign dec_use = {dec_use_rs2_i, dec_use_rs1_i};

  hz_track #(.AW(AW), .N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_o),
    .dec_valid_i (dec_valid_i),
    .dec_wr_i    (dec_wr_i),
    .dec_load_i  (dec_load_i),
    .dec_rd_i    (dec_rd_i),
    .dec_rs_i    (dec_rs),
    .dec_use_i   (dec_use),
    .st_valid_o  (st_valid),
    .st_wr_o     (st_wr),
    .st_rd_o     (st_rd),
    .dc_load_o   (dc_load),
    .dc_rs_o     (dc_rs),
    .dc_use_o    (dc_use)
  );

  hz_stall #(.AW(AW), .N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_stall (
    .fwd_en_i    (fwd_en_i),
    .dec_valid_i (dec_valid_i),
    .dec_rs_i    (dec_rs),
    .dec_use_i   (dec_use),
    .st_valid_i  (st_valid),
    .st_wr_i     (st_wr),
    .st_rd_i     (st_rd),
    .dc_load_i   (dc_load),
    .stall_o     (stall_o),
    .wb_byp_o    (wb_byp)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_sel
    hz_fwd_sel #(.AW(AW)) u_sel (
      .fwd_en_i   (fwd_en_i),
      .dc_valid_i (st_valid[0]),
      .src_i      (dc_rs[k]),
      .use_i      (dc_use[k]),
      .cm_valid_i (st_valid[S_CM]),
      .cm_wr_i    (st_wr[S_CM]),
      .cm_rd_i    (st_rd[S_CM]),
      .mw_valid_i (st_valid[S_MW]),
      .mw_wr_i    (st_wr[S_MW]),
      .mw_rd_i    (st_rd[S_MW]),
      .sel_o      (sel[k])
    );
  end

  assign fwd_a_o    = sel[0];
  assign fwd_b_o    = sel[1];
  assign wb_byp_a_o = wb_byp[0];
  assign wb_byp_b_o = wb_byp[1];
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fwd_en_i,
  input logic          dec_valid_i,
  input logic [AW-1:0] dec_rs1_i,
  input logic [AW-1:0] dec_rs2_i,
  input logic          stall_o,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          wb_byp_a_o,
  input logic          wb_byp_b_o,
  input logic          dc_load_i
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !stall_o && !wb_byp_a_o && !wb_byp_b_o);

  p_one_bubble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && fwd_en_i) |=> (!stall_o || !fwd_en_i));

  p_sel_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o != 2'b11 && fwd_b_o != 2'b11);

  p_reg0_no_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rs1_i == '0 && dec_rs2_i == '0) |-> !stall_o && !wb_byp_a_o && !wb_byp_b_o);

  p_off_sel_rf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_en_i |-> fwd_a_o == 2'b00 && fwd_b_o == 2'b00);

  p_byp_needs_fwd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_byp_a_o || wb_byp_b_o) |-> fwd_en_i && !stall_o);

  p_stall_only_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && fwd_en_i) |-> dc_load_i);
endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fwd_en_i    (fwd_en_i),
  .dec_valid_i (dec_valid_i),
  .dec_rs1_i   (dec_rs1_i),
  .dec_rs2_i   (dec_rs2_i),
  .stall_o     (stall_o),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .wb_byp_a_o  (wb_byp_a_o),
  .wb_byp_b_o  (wb_byp_b_o),
  .dc_load_i   (dc_load)
);

// File: tb/tb_hz_unit.sv
module tb_hz_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 32;
  localparam int AW         = $clog2(NUM_REGS);
  localparam int WD_CYCLES  = 60000;
  localparam int N_RAND     = 3000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fwd_en_i = 1'b1, dec_valid_i = 1'b0;
  logic [AW-1:0] dec_rs1_i = '0, dec_rs2_i = '0, dec_rd_i = '0;
  logic dec_use_rs1_i = 1'b0, dec_use_rs2_i = 1'b0, dec_wr_i = 1'b0, dec_load_i = 1'b0;
  logic stall_o, wb_byp_a_o, wb_byp_b_o;
  logic [1:0] fwd_a_o, fwd_b_o;

  hz_unit #(.NUM_REGS(NUM_REGS)) dut (.*, .clk_i(clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // pending decode instruction and mode
  bit p_fwd = 1, p_v = 0, p_wr = 0, p_ld = 0, p_u1 = 0, p_u2 = 0;
  logic [AW-1:0] p_rd = '0, p_rs1 = '0, p_rs2 = '0;

  // bench pipeline model: slot 0 = decode/compute, 1 = compute/memory, 2 = memory/writeback
  bit m_v[3], m_wr[3], m_ld0, m_u1, m_u2;
  logic [AW-1:0] m_rd[3], m_rs1, m_rs2;

  int obs_fa, obs_fb, obs_ba, obs_bb;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit hit(bit v, bit wr, logic [AW-1:0] rd, logic [AW-1:0] src, bit u);
    return v && wr && u && (rd != '0) && (rd == src);
  endfunction

  function automatic int exp_sel(logic [AW-1:0] src, bit u);
    if (!p_fwd || !m_v[0]) return 0;
    if (hit(m_v[1], m_wr[1], m_rd[1], src, u)) return 1;
    if (hit(m_v[2], m_wr[2], m_rd[2], src, u)) return 2;
    return 0;
  endfunction

  task automatic step(output bit st);
    bit e_stall, any;
    @(negedge clk);
    fwd_en_i = p_fwd; dec_valid_i = p_v; dec_wr_i = p_wr; dec_load_i = p_ld;
    dec_rd_i = p_rd; dec_rs1_i = p_rs1; dec_rs2_i = p_rs2;
    dec_use_rs1_i = p_u1; dec_use_rs2_i = p_u2;
    #1;
    any = 0;
    for (int s = 0; s < 3; s++)
      any |= hit(m_v[s], m_wr[s], m_rd[s], p_rs1, p_u1) | hit(m_v[s], m_wr[s], m_rd[s], p_rs2, p_u2);
    if (!p_v) e_stall = 0;
    else if (p_fwd)
      e_stall = m_ld0 && (hit(m_v[0], m_wr[0], m_rd[0], p_rs1, p_u1) ||
                          hit(m_v[0], m_wr[0], m_rd[0], p_rs2, p_u2));
    else e_stall = any;
    chk(p_fwd ? "R2 stall" : "R7 stall", int'(stall_o), int'(e_stall));
    chk("R3 sel a", int'(fwd_a_o), exp_sel(m_rs1, m_u1));
    chk("R3 sel b", int'(fwd_b_o), exp_sel(m_rs2, m_u2));
    chk("R9 byp a", int'(wb_byp_a_o),
        int'(p_fwd && p_v && !e_stall && hit(m_v[2], m_wr[2], m_rd[2], p_rs1, p_u1)));
    chk("R9 byp b", int'(wb_byp_b_o),
        int'(p_fwd && p_v && !e_stall && hit(m_v[2], m_wr[2], m_rd[2], p_rs2, p_u2)));
    obs_fa = fwd_a_o; obs_fb = fwd_b_o; obs_ba = wb_byp_a_o; obs_bb = wb_byp_b_o;
    @(posedge clk); #1;
    for (int s = 2; s > 0; s--) begin
      m_v[s] = m_v[s-1]; m_wr[s] = m_wr[s-1]; m_rd[s] = m_rd[s-1];
    end
    if (e_stall || !p_v) begin
      m_v[0] = 0; m_wr[0] = 0; m_ld0 = 0; m_u1 = 0; m_u2 = 0;
    end else begin
      m_v[0] = 1; m_wr[0] = p_wr; m_rd[0] = p_rd; m_ld0 = p_ld;
      m_rs1 = p_rs1; m_rs2 = p_rs2; m_u1 = p_u1; m_u2 = p_u2;
    end
    st = e_stall;
  endtask

  task automatic issue(bit v, bit wr, bit ld, int rd, int rs1, bit u1, int rs2, bit u2,
                       output int stalls);
    bit st;
    p_v = v; p_wr = wr; p_ld = ld; p_rd = AW'(rd);
    p_rs1 = AW'(rs1); p_u1 = u1; p_rs2 = AW'(rs2); p_u2 = u2;
    stalls = 0;
    do begin
      step(st);
      if (st) stalls++;
    end while (st && stalls < 8);
  endtask

  task automatic nop();
    int d;
    issue(0, 0, 0, 0, 0, 0, 0, 0, d);
  endtask

  initial begin
    int ns;
    void'($urandom(32'h1d5eed));
    for (int s = 0; s < 3; s++) begin m_v[s] = 0; m_wr[s] = 0; m_rd[s] = '0; end
    m_ld0 = 0; m_u1 = 0; m_u2 = 0; m_rs1 = '0; m_rs2 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 reset stall", int'(stall_o), 0);
    chk("R1 reset sel a", int'(fwd_a_o), 0);
    chk("R1 reset sel b", int'(fwd_b_o), 0);
    chk("R1 reset byp", int'(wb_byp_a_o | wb_byp_b_o), 0);

    p_fwd = 1;
    // distance 1 ALU producer
    issue(1, 1, 0, 1, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 1, 1, 0, 0, ns);
    chk("R10 alu no stall", ns, 0);
    nop(); chk("R3 sel from CM", obs_fa, 1);
    // distance 2 on operand B
    issue(1, 1, 0, 2, 0, 0, 0, 0, ns); nop();
    issue(1, 1, 0, 9, 0, 0, 2, 1, ns);
    nop(); chk("R4 sel b from MW", obs_fb, 2);
    // two writers, younger wins
    issue(1, 1, 0, 3, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 3, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 3, 1, 3, 1, ns);
    nop(); chk("R5 younger a", obs_fa, 1); chk("R5 younger b", obs_fb, 1);
    // load-use
    issue(1, 1, 1, 4, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 4, 1, 0, 0, ns);
    chk("R2 load-use one bubble", ns, 1);
    nop(); chk("R8 after bubble sel MW", obs_fa, 2);
    // register 0, non-writer, unused source
    issue(1, 1, 1, 0, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 0, 1, 0, 1, ns);
    chk("R6 r0 load no stall", ns, 0);
    nop(); chk("R6 r0 sel a", obs_fa, 0);
    issue(1, 0, 1, 5, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 5, 1, 0, 0, ns);
    chk("R6 non-writer no stall", ns, 0);
    issue(1, 1, 1, 6, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 0, 0, 6, 0, ns);
    chk("R6 unused source no stall", ns, 0);
    nop(); chk("R6 unused sel b", obs_fb, 0);
    // distance 3: writeback bypass
    issue(1, 1, 0, 7, 0, 0, 0, 0, ns); nop(); nop();
    issue(1, 1, 0, 9, 7, 1, 0, 0, ns);
    chk("R9 byp a at distance 3", obs_ba, 1);
    chk("R9 no stall at distance 3", ns, 0);
    nop(); nop(); nop();

    // forwarding off
    p_fwd = 0;
    issue(1, 1, 0, 1, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 1, 1, 0, 0, ns);
    chk("R7 distance 1 stalls 3", ns, 3);
    nop(); chk("R7 sel stays RF", obs_fa, 0);
    issue(1, 1, 0, 2, 0, 0, 0, 0, ns); nop();
    issue(1, 1, 0, 9, 0, 0, 2, 1, ns);
    chk("R7 distance 2 stalls 2", ns, 2);
    issue(1, 1, 1, 3, 0, 0, 0, 0, ns);
    issue(1, 1, 0, 9, 3, 1, 0, 0, ns);
    chk("R7 load distance 1 stalls 3", ns, 3);
    nop(); nop(); nop();

    // constrained random against the model
    p_fwd = 1;
    for (int i = 0; i < N_RAND; i++) begin
      if ($urandom % 50 == 0) p_fwd = ~p_fwd;
      if ($urandom % 5 == 0) nop();
      else issue(1, ($urandom % 6) != 0, ($urandom % 3) == 0, $urandom % 4,
                 $urandom % 4, ($urandom % 4) != 0, $urandom % 4, ($urandom % 3) != 0, ns);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule